// File: doc/BRIEF.md
# CEC Line Control Register Block

This block holds the control settings for a Consumer Electronics Control line interface and sits between a simple synchronous register bus and the transceiver core. Software writes a four-bit control register that carries a transmit enable, a receive enable, a level-held clear for the line-activity flag, and a switch that makes the transceiver disregard the end-of-message indication. Enable changes are not applied to the transceiver as soon as they are written. Each enable passes through a small state machine. A change takes effect one clock after the register bit changes. When a transfer is in progress, a disable is held back until the transceiver reports that the acknowledge bit has finished.

A second state machine keeps a sticky flag. The flag records that the CEC line, after a two-flop synchronizer, has been seen low. The clear bit does not clear itself. While it is 1, the flag is forced to 0. When it is written back to 0 and the line is still low, the flag returns to 1 on the next clock.

The enable machine has three states:
- EN_OFF drives 0 and moves to EN_ON when the request bit is 1.
- EN_ON drives 1. When the request drops it moves to EN_DRAIN if the transceiver is busy, and to EN_OFF if it is not.
- EN_DRAIN drives 1. It returns to EN_ON if the request comes back, and moves to EN_OFF on the acknowledge-end pulse or when busy falls.

The flag machine has three states:
- FLG_IDLE drives 0 and moves to FLG_SET on a synchronized low.
- FLG_SET drives 1 and holds there.
- FLG_HOLD drives 0. Any state enters FLG_HOLD while the clear bit is 1. On release it leaves to FLG_SET if the line is low and to FLG_IDLE if it is high.

Top module: `cec_ctrl_regs`

## Requirements
- R1: After reset the control register reads 0x00, both effective enables and the end-of-message-ignore output are 0, and the flag is 0.
- R2: The control register is at address 0. Bit 0 is transmit enable, bit 1 is receive enable, bit 2 is flag clear and bit 3 is end-of-message ignore. Bits 7 to 4 ignore writes and read as 0.
- R3: When no transfer is busy, a change of an enable bit reaches its effective enable output one clock after the write edge, and not on the write edge itself.
- R4: If transmit enable is cleared while `xfer_busy` is 1, `tx_en_eff` stays 1 until the clock that samples `ack_done` high, and then drops.
- R5: If receive enable is cleared while `xfer_busy` is 1, `rx_en_eff` stays 1 until the clock that samples `ack_done` high, and then drops.
- R6: `cec_line_in` passes through a two-flop synchronizer. With the clear bit at 0, a low line sets `edge_flag` on the third clock edge after the line falls. The flag then stays 1 after the line returns high.
- R7: While the clear bit is 1, `edge_flag` is 0 from the clock after the write, whatever the line level.
- R8: When the clear bit is written back to 0, the flag returns to 1 one clock later if the synchronized line is low, and stays 0 if the line is high.
- R9: Re-enabling a channel while its disable is pending keeps the effective enable at 1, and a later `ack_done` does not drop it.
- R10: A read of address 1 returns the flag in bit 0 and 0 in bits 7 to 1.
- R11: `eom_ignore` equals control bit 3 from the clock edge that writes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address (0 control, 1 flag) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rd_en is 1, 0 otherwise |
| cec_line_in | input | 1 | CEC line level, asynchronous |
| xfer_busy | input | 1 | Transceiver reports a transfer in progress |
| ack_done | input | 1 | One-clock pulse at the end of the acknowledge bit |
| tx_en_eff | output | 1 | Effective transmit enable to the transceiver |
| rx_en_eff | output | 1 | Effective receive enable to the transceiver |
| eom_ignore | output | 1 | Transceiver disregards end-of-message when 1 |
| edge_flag | output | 1 | Line-low detect flag |

## Verification
The assertions check on every cycle the rules that hold from cycle to cycle:
- an effective enable never rises unless its register bit was set one clock earlier;
- neither enable drops while a transfer is busy and no acknowledge-end pulse has arrived;
- a set clear bit forces the flag low on the next clock;
- a synchronized low with the clear bit at 0 sets the flag.

Only the directed scenarios can show the exact latencies and the orderings:
- the three-edge path from the line pin to the flag;
- the flag returning when the clear bit is released over a low line, and not returning over a high line;
- a re-enable cancelling a pending disable;
- the register map read back through the bus.

// File: rtl/cec_ctrl_pkg.sv
package cec_ctrl_pkg;

    // Control register field positions.
    localparam int CTRL_BITS   = 4;
    localparam int BIT_TX_EN   = 0;
    localparam int BIT_RX_EN   = 1;
    localparam int BIT_FLG_CLR = 2;
    localparam int BIT_EOM_IGN = 3;
    localparam int NUM_CHAN    = 2;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_ON    = 2'd1,
        EN_DRAIN = 2'd2
    } en_state_t;

    typedef enum logic [1:0] {
        FLG_IDLE = 2'd0,
        FLG_SET  = 2'd1,
        FLG_HOLD = 2'd2
    } flag_state_t;

endpackage

// File: rtl/cec_line_sync.sv
module cec_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            // The line idles high, so every stage resets to 1.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], d_async};
            end
        end
    endgenerate

    assign d_sync = chain_q[LAST];
endmodule

// File: rtl/cec_enable_fsm.sv
module cec_enable_fsm
    import cec_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic ack_done,
    output logic en_out
);
    en_state_t state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF:   if (req) state_d = EN_ON;
            EN_ON:    if (!req) state_d = busy ? EN_DRAIN : EN_OFF;
            EN_DRAIN: begin
                if (req)                   state_d = EN_ON;
                else if (ack_done || !busy) state_d = EN_OFF;
            end
            default:  state_d = EN_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_OFF;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            EN_ON, EN_DRAIN: en_out = 1'b1;
            default:         en_out = 1'b0;
        endcase
    end

    AST_DRAIN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_DRAIN) |-> $past(busy)) else $error("drain entered without busy"); // R4
endmodule

// File: rtl/cec_edge_flag_fsm.sv
module cec_edge_flag_fsm
    import cec_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_level,
    input  logic line_sync,
    output logic flag
);
    flag_state_t state_q, state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (clr_level)       state_d = FLG_HOLD;
                else if (!line_sync) state_d = FLG_SET;
            end
            FLG_SET:  if (clr_level) state_d = FLG_HOLD;
            FLG_HOLD: if (!clr_level) state_d = line_sync ? FLG_IDLE : FLG_SET;
            default:  state_d = FLG_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            FLG_SET: flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

    AST_CLEAR_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr_level |=> !flag) else $error("flag high with clear held"); // R7
    AST_LOW_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_sync && !clr_level) |=> flag) else $error("low line missed"); // R6
endmodule

// File: rtl/cec_ctrl_regs.sv
module cec_ctrl_regs
    import cec_ctrl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cec_line_in,
    input  logic              xfer_busy,
    input  logic              ack_done,
    output logic              tx_en_eff,
    output logic              rx_en_eff,
    output logic              eom_ignore,
    output logic              edge_flag
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(1);

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [NUM_CHAN-1:0]  en_vec;
    logic                 line_s;
    logic                 unused_wbits;

    // Upper write bits are ignored.
    assign unused_wbits = ^wdata[DATA_W-1:CTRL_BITS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_q <= '0;
        else if (wr_en && addr == CTRL_ADDR) ctrl_q <= wdata[CTRL_BITS-1:0];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == CTRL_ADDR)      rdata[CTRL_BITS-1:0] = ctrl_q;
            else if (addr == FLAG_ADDR) rdata[0] = edge_flag;
        end
    end

    // One deferred-enable machine per channel: index 0 transmit, index 1 receive.
    generate
        for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
            cec_enable_fsm u_en (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (ctrl_q[BIT_TX_EN + g]),
                .busy     (xfer_busy),
                .ack_done (ack_done),
                .en_out   (en_vec[g])
            );
        end
    endgenerate

    assign tx_en_eff  = en_vec[0];
    assign rx_en_eff  = en_vec[1];
    assign eom_ignore = ctrl_q[BIT_EOM_IGN];

    cec_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cec_line_in),
        .d_sync  (line_s)
    );

    cec_edge_flag_fsm u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_level (ctrl_q[BIT_FLG_CLR]),
        .line_sync (line_s),
        .flag      (edge_flag)
    );

    AST_TX_RISE_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en_eff) |-> $past(ctrl_q[BIT_TX_EN])) else $error("tx early"); // R3
    AST_RX_RISE_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en_eff) |-> $past(ctrl_q[BIT_RX_EN])) else $error("rx early"); // R3
    AST_TX_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_eff && xfer_busy && !ack_done) |=> tx_en_eff) else $error("tx dropped"); // R4
    AST_RX_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_eff && xfer_busy && !ack_done) |=> rx_en_eff) else $error("rx dropped"); // R5
endmodule

// File: tb/cec_ctrl_regs_tb.sv
module cec_ctrl_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cec_line_in = 1'b1;
    logic       xfer_busy = 1'b0;
    logic       ack_done = 1'b0;
    logic       tx_en_eff, rx_en_eff, eom_ignore, edge_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cec_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cec_line_in(cec_line_in),
        .xfer_busy(xfer_busy), .ack_done(ack_done), .tx_en_eff(tx_en_eff),
        .rx_en_eff(rx_en_eff), .eom_ignore(eom_ignore), .edge_flag(edge_flag)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // The register updates on the posedge inside this task.
    task automatic wr(input logic [0:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [0:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, v);
        check("R1 ctrl", v, 8'h00);
        check("R1 outputs", {4'b0, tx_en_eff, rx_en_eff, eom_ignore, edge_flag}, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(1'b0, 8'hF8);
        rd(1'b0, v);
        check("R2 upper ignored", v, 8'h08);
        check("R11 eom_ignore", {7'b0, eom_ignore}, 8'h01);
        check("R2 no enable", {6'b0, tx_en_eff, rx_en_eff}, 8'h00);
        wr(1'b0, 8'h00);
        check("R11 eom cleared", {7'b0, eom_ignore}, 8'h00);
    endtask

    task automatic t_enable_idle();
        wr(1'b0, 8'h01);
        check("R3 tx not yet", {7'b0, tx_en_eff}, 8'h00);
        cyc(1);
        check("R3 tx on", {7'b0, tx_en_eff}, 8'h01);
        wr(1'b0, 8'h02);
        check("R3 tx still on", {7'b0, tx_en_eff}, 8'h01);
        cyc(1);
        check("R3 tx off rx on", {6'b0, tx_en_eff, rx_en_eff}, 8'h01);
        wr(1'b0, 8'h00);
        cyc(1);
        check("R3 rx off", {7'b0, rx_en_eff}, 8'h00);
    endtask

    task automatic t_tx_drain();
        wr(1'b0, 8'h03);
        cyc(1);
        xfer_busy = 1'b1;
        wr(1'b0, 8'h02);
        cyc(3);
        check("R4 tx held", {7'b0, tx_en_eff}, 8'h01);
        pulse_ack();
        check("R4 tx dropped", {7'b0, tx_en_eff}, 8'h00);
        check("R4 rx kept", {7'b0, rx_en_eff}, 8'h01);
        xfer_busy = 1'b0;
        wr(1'b0, 8'h00);
        cyc(1);
    endtask

    task automatic t_rx_drain();
        wr(1'b0, 8'h03);
        cyc(1);
        xfer_busy = 1'b1;
        wr(1'b0, 8'h01);
        cyc(3);
        check("R5 rx held", {7'b0, rx_en_eff}, 8'h01);
        pulse_ack();
        check("R5 rx dropped", {7'b0, rx_en_eff}, 8'h00);
        xfer_busy = 1'b0;
        wr(1'b0, 8'h00);
        cyc(1);
        check("R3 all off", {6'b0, tx_en_eff, rx_en_eff}, 8'h00);
    endtask

    task automatic t_reenable();
        wr(1'b0, 8'h01);
        cyc(1);
        xfer_busy = 1'b1;
        wr(1'b0, 8'h00);
        cyc(1);
        wr(1'b0, 8'h01);
        cyc(1);
        check("R9 tx kept", {7'b0, tx_en_eff}, 8'h01);
        pulse_ack();
        cyc(1);
        check("R9 tx after ack", {7'b0, tx_en_eff}, 8'h01);
        xfer_busy = 1'b0;
        wr(1'b0, 8'h00);
        cyc(1);
    endtask

    task automatic t_flag();
        logic [7:0] v;
        @(negedge clk);
        cec_line_in = 1'b0;
        cyc(2);
        check("R6 flag latency", {7'b0, edge_flag}, 8'h00);
        cyc(1);
        check("R6 flag set", {7'b0, edge_flag}, 8'h01);
        cec_line_in = 1'b1;
        cyc(4);
        check("R6 flag sticky", {7'b0, edge_flag}, 8'h01);
        rd(1'b1, v);
        check("R10 flag read", v, 8'h01);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        wr(1'b0, 8'h04);
        cyc(1);
        check("R7 cleared", {7'b0, edge_flag}, 8'h00);
        cec_line_in = 1'b0;
        cyc(5);
        check("R7 held low", {7'b0, edge_flag}, 8'h00);
        wr(1'b0, 8'h00);
        cyc(1);
        check("R8 reassert", {7'b0, edge_flag}, 8'h01);
        wr(1'b0, 8'h04);
        cec_line_in = 1'b1;
        cyc(4);
        wr(1'b0, 8'h00);
        cyc(3);
        check("R8 stays clear", {7'b0, edge_flag}, 8'h00);
        rd(1'b1, v);
        check("R10 flag read zero", v, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_regmap();
        t_enable_idle();
        t_tx_drain();
        t_rx_drain();
        t_reenable();
        t_flag();
        t_clear();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule